// File: doc/BRIEF.md
# Segmented Address Generation Unit

This block sits between an instruction engine and a 16-bit memory bus. It turns a 16-bit segment value and a 16-bit offset into a 20-bit physical byte address. The segment is chosen from four internal segment registers: code, data, stack and extra. The choice follows the class of the access. A one-shot override can redirect the next data or stack access to any of the four registers. The block then runs the bus cycles that the access needs. Words are stored low byte first. A word that starts at an odd address is split into two byte cycles, and the two bytes are joined before the result is returned.

The upstream side holds `req_i` and its attributes until it sees a one-cycle `ready_o` pulse, and then drops `req_i`. The memory side holds `mem_req_o`, the address, the byte enables and the write data steady until `mem_ack_i` is high at a clock edge. Lane 0 (`[7:0]`) carries the byte at the even address of a 16-bit pair, and lane 1 (`[15:8]`) carries the byte at the odd address. At reset the code segment holds FFFFh and the other segments hold zero. As a result, the first fetch at offset 0 goes to FFFF0h.

Top module: `seg_agu`

## Requirements
- R1: Reset leaves `ready_o` and `mem_req_o` low. It loads the code segment with FFFFh and the data, stack and extra segments with 0000h. A fetch at offset 0 after reset addresses FFFF0h.
- R2: The physical address is segment*16 + offset. Any carry beyond bit 19 is dropped.
- R3: The default segment comes from the access class `cls_i`: 0 (fetch) uses code, 1 (data) uses data, 2 (stack) uses stack, and 3 (string destination) uses extra.
- R4: A pulse on `ovr_set_i` records `ovr_seg_i` (0 extra, 1 code, 2 stack, 3 data) as a pending override. The next accepted data or stack access uses that override and clears it. Fetch and string-destination accesses neither use the override nor clear it.
- R5: When `seg_wr_i` is high at a clock edge, the segment register chosen by `seg_wr_sel_i` (same encoding as R4) takes the value of `seg_wr_data_i`. Every access accepted after that edge uses the new value.
- R6: A word access at an even address takes one bus cycle with `mem_be_o`=11. A read returns `mem_rdata_i` unchanged.
- R7: A word access at an odd address P takes two cycles. The first is at P with `mem_be_o`=10 and moves the low byte on lane 1. The second is at P+1 with `mem_be_o`=01 and moves the high byte on lane 0. `ready_o` comes only after the second cycle.
- R8: A byte access takes one cycle. It uses `mem_be_o`=01 at an even address and 10 at an odd address. A read returns the byte zero-extended on `rdata_o[7:0]`.
- R9: Write data is placed on the lanes as follows. An even word goes out unchanged. An odd word sends its low byte and then its high byte, each copied onto both lanes. A byte write copies `wdata_i[7:0]` onto both lanes.
- R10: The second cycle of an odd word at FFFFFh addresses 00000h.
- R11: `mem_req_o` and its address, enables, direction and data stay stable until acknowledged. `ready_o` is a single-cycle pulse, raised in the cycle after the final acknowledge, and never together with `mem_req_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| seg_wr_i | input | 1 | Segment register load strobe |
| seg_wr_sel_i | input | 2 | Segment to load (0 extra, 1 code, 2 stack, 3 data) |
| seg_wr_data_i | input | 16 | Segment load value |
| ovr_set_i | input | 1 | Record a one-shot segment override |
| ovr_seg_i | input | 2 | Override segment |
| req_i | input | 1 | Access request, held until ready |
| cls_i | input | 2 | Access class (0 fetch, 1 data, 2 stack, 3 string destination) |
| offset_i | input | 16 | Offset within segment |
| word_i | input | 1 | 1 for word access, 0 for byte access |
| we_i | input | 1 | 1 for write |
| wdata_i | input | 16 | Write data |
| ready_o | output | 1 | Access complete pulse |
| rdata_o | output | 16 | Read result, valid with ready_o |
| mem_req_o | output | 1 | Bus cycle request |
| mem_we_o | output | 1 | Bus cycle direction |
| mem_addr_o | output | 20 | Physical byte address |
| mem_be_o | output | 2 | Lane enables |
| mem_wdata_o | output | 16 | Bus write data |
| mem_ack_i | input | 1 | Bus cycle acknowledge |
| mem_rdata_i | input | 16 | Bus read data |

## Verification
The accesses cover every class, with both the reset segment values and freshly loaded ones. This separates the default choice of segment from the relocation sum. Byte, even-word and odd-word reads and writes are run with zero and with two wait states. These runs show whether the split path, the lane placement and the assembly order are right, and whether bus signals stay steady while an acknowledge is pending. Override sequences place a fetch and a string-destination access between the prefix and its target, which shows whether the override is used and cleared only by the correct access. Sums that pass the top of the 1 MB space check the wrap of both the relocation and the split increment.

// File: rtl/seg_agu_pkg.sv
package seg_agu_pkg;
  typedef enum logic [1:0] {SEG_ES = 2'd0, SEG_CS = 2'd1, SEG_SS = 2'd2, SEG_DS = 2'd3} seg_id_e;
  typedef enum logic [1:0] {CLS_FETCH = 2'd0, CLS_DATA = 2'd1, CLS_STACK = 2'd2, CLS_STRDST = 2'd3} acc_cls_e;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_CYC1 = 2'd1, ST_CYC2 = 2'd2, ST_DONE = 2'd3} seq_st_e;
endpackage

// File: rtl/seg_agu_segfile.sv
module seg_agu_segfile
  import seg_agu_pkg::*;
#(
  parameter int unsigned SEG_W = 16,
  parameter int unsigned NSEG = 4,
  parameter logic [SEG_W-1:0] RESET_CS = '1,
  localparam int unsigned SEL_W = $clog2(NSEG)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [SEL_W-1:0] wr_sel_i,
  input  logic [SEG_W-1:0] wr_data_i,
  input  logic             ovr_set_i,
  input  logic [SEL_W-1:0] ovr_seg_i,
  input  logic             take_i,
  input  logic [1:0]       cls_i,
  output logic [SEG_W-1:0] seg_o
);
  localparam int unsigned CS_IDX = int'(SEG_CS);

  logic [SEG_W-1:0] seg_q [NSEG];
  logic             ovr_vld_q;
  logic [SEL_W-1:0] ovr_id_q;
  logic [SEL_W-1:0] dflt_id, sel_id;
  logic             ovr_ok;

  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    localparam logic [SEG_W-1:0] RST_V = (g == CS_IDX) ? RESET_CS : '0;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) seg_q[g] <= RST_V;
      else if (wr_i && (wr_sel_i == SEL_W'(g))) seg_q[g] <= wr_data_i;
    end
  end

  always_comb begin
    unique case (acc_cls_e'(cls_i))
      CLS_FETCH: dflt_id = SEL_W'(SEG_CS);
      CLS_DATA:  dflt_id = SEL_W'(SEG_DS);
      CLS_STACK: dflt_id = SEL_W'(SEG_SS);
      default:   dflt_id = SEL_W'(SEG_ES);
    endcase
  end

  // only data and stack classes honour a prefix
  assign ovr_ok = (acc_cls_e'(cls_i) == CLS_DATA) || (acc_cls_e'(cls_i) == CLS_STACK);
  assign sel_id = (ovr_ok && ovr_vld_q) ? ovr_id_q : dflt_id;
  assign seg_o  = seg_q[sel_id];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovr_vld_q <= 1'b0;
      ovr_id_q  <= '0;
    end else if (ovr_set_i) begin
      ovr_vld_q <= 1'b1;
      ovr_id_q  <= ovr_seg_i;
    end else if (take_i && ovr_ok) begin
      ovr_vld_q <= 1'b0;
    end
  end
endmodule

// File: rtl/seg_agu_reloc.sv
module seg_agu_reloc #(
  parameter int unsigned SEG_W = 16,
  parameter int unsigned OFF_W = 16,
  parameter int unsigned SHIFT = 4,
  localparam int unsigned ADDR_W = SEG_W + SHIFT
) (
  input  logic [SEG_W-1:0]  seg_i,
  input  logic [OFF_W-1:0]  off_i,
  output logic [ADDR_W-1:0] phys_o
);
  logic [ADDR_W-1:0] base, disp;

  assign base   = {seg_i, {SHIFT{1'b0}}};
  assign disp   = ADDR_W'(off_i);
  assign phys_o = base + disp; // carry past the top bit is dropped
endmodule

// File: rtl/seg_agu_seq.sv
module seg_agu_seq
  import seg_agu_pkg::*;
#(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned DATA_W = 2 * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              word_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] phys_i,
  output logic              take_o,
  output logic              ready_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [1:0]        mem_be_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  seq_st_e           st_q;
  logic [ADDR_W-1:0] addr_q;
  logic              word_q, we_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              odd, split;

  assign odd    = addr_q[0];
  assign split  = word_q && odd;
  assign take_o = (st_q == ST_IDLE) && req_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      addr_q  <= '0;
      word_q  <= 1'b0;
      we_q    <= 1'b0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (req_i) begin
          addr_q  <= phys_i;
          word_q  <= word_i;
          we_q    <= we_i;
          wdata_q <= wdata_i;
          st_q    <= ST_CYC1;
        end
        ST_CYC1: if (mem_ack_i) begin
          if (split) begin
            rdata_q[BYTE_W-1:0] <= mem_rdata_i[DATA_W-1:BYTE_W];
            addr_q              <= addr_q + 1'b1;
            st_q                <= ST_CYC2;
          end else begin
            if (word_q)   rdata_q <= mem_rdata_i;
            else if (odd) rdata_q <= {{BYTE_W{1'b0}}, mem_rdata_i[DATA_W-1:BYTE_W]};
            else          rdata_q <= {{BYTE_W{1'b0}}, mem_rdata_i[BYTE_W-1:0]};
            st_q <= ST_DONE;
          end
        end
        ST_CYC2: if (mem_ack_i) begin
          rdata_q[DATA_W-1:BYTE_W] <= mem_rdata_i[BYTE_W-1:0];
          st_q                     <= ST_DONE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_be_o    = odd ? 2'b10 : 2'b01;
    mem_wdata_o = {2{wdata_q[BYTE_W-1:0]}};
    if (st_q == ST_CYC1 && word_q && !odd) begin
      mem_be_o    = 2'b11;
      mem_wdata_o = wdata_q;
    end else if (st_q == ST_CYC2) begin
      mem_wdata_o = {2{wdata_q[DATA_W-1:BYTE_W]}};
    end
  end

  assign mem_req_o  = (st_q == ST_CYC1) || (st_q == ST_CYC2);
  assign mem_we_o   = we_q;
  assign mem_addr_o = addr_q;
  assign ready_o    = (st_q == ST_DONE);
  assign rdata_o    = rdata_q;
endmodule

// File: rtl/seg_agu.sv
module seg_agu #(
  parameter int unsigned SEG_W = 16,
  parameter int unsigned OFF_W = 16,
  parameter int unsigned SHIFT = 4,
  parameter int unsigned BYTE_W = 8,
  parameter logic [SEG_W-1:0] RESET_CS = '1,
  localparam int unsigned ADDR_W = SEG_W + SHIFT,
  localparam int unsigned DATA_W = 2 * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              seg_wr_i,
  input  logic [1:0]        seg_wr_sel_i,
  input  logic [SEG_W-1:0]  seg_wr_data_i,
  input  logic              ovr_set_i,
  input  logic [1:0]        ovr_seg_i,
  input  logic              req_i,
  input  logic [1:0]        cls_i,
  input  logic [OFF_W-1:0]  offset_i,
  input  logic              word_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ready_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [1:0]        mem_be_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  logic [SEG_W-1:0]  seg_val;
  logic [ADDR_W-1:0] phys;
  logic              take;

  seg_agu_segfile #(.SEG_W(SEG_W), .NSEG(4), .RESET_CS(RESET_CS)) u_segfile (
    .clk_i, .rst_ni,
    .wr_i(seg_wr_i), .wr_sel_i(seg_wr_sel_i), .wr_data_i(seg_wr_data_i),
    .ovr_set_i, .ovr_seg_i, .take_i(take), .cls_i, .seg_o(seg_val)
  );

  seg_agu_reloc #(.SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT)) u_reloc (
    .seg_i(seg_val), .off_i(offset_i), .phys_o(phys)
  );

  seg_agu_seq #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_seq (
    .clk_i, .rst_ni, .req_i, .word_i, .we_i, .wdata_i, .phys_i(phys),
    .take_o(take), .ready_o, .rdata_o,
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_be_o, .mem_wdata_o,
    .mem_ack_i, .mem_rdata_i
  );
endmodule

// File: rtl/seg_agu_chk.sv
module seg_agu_chk #(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ready_o,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic              mem_ack_i,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [1:0]        mem_be_o,
  input logic [DATA_W-1:0] mem_wdata_o
);
  p_hold_until_ack_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_be_o)
                                && $stable(mem_we_o) && $stable(mem_wdata_o));

  p_ready_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o);

  p_ready_after_ack_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> $past(mem_ack_i) && !mem_req_o);

  p_even_word_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_be_o == 2'b11 |-> !mem_addr_o[0]);

  p_byte_lane_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_be_o != 2'b11 |-> mem_be_o == (mem_addr_o[0] ? 2'b10 : 2'b01));

  p_split_follow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_ack_i ##1 mem_req_o |-> mem_be_o == 2'b01 && !mem_addr_o[0]);
endmodule

bind seg_agu seg_agu_chk u_chk (.*);

// File: tb/seg_agu_tb.sv
module seg_agu_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        seg_wr_i = 1'b0;
  logic [1:0]  seg_wr_sel_i = '0;
  logic [15:0] seg_wr_data_i = '0;
  logic        ovr_set_i = 1'b0;
  logic [1:0]  ovr_seg_i = '0;
  logic        req_i = 1'b0;
  logic [1:0]  cls_i = '0;
  logic [15:0] offset_i = '0;
  logic        word_i = 1'b0;
  logic        we_i = 1'b0;
  logic [15:0] wdata_i = '0;
  logic        ready_o;
  logic [15:0] rdata_o;
  logic        mem_req_o, mem_we_o;
  logic [19:0] mem_addr_o;
  logic [1:0]  mem_be_o;
  logic [15:0] mem_wdata_o;
  logic        mem_ack_i = 1'b0;
  logic [15:0] mem_rdata_i = '0;

  always #4 clk = ~clk; // 125 MHz

  seg_agu u_dut (
    .clk_i(clk), .rst_ni, .seg_wr_i, .seg_wr_sel_i, .seg_wr_data_i,
    .ovr_set_i, .ovr_seg_i, .req_i, .cls_i, .offset_i, .word_i, .we_i, .wdata_i,
    .ready_o, .rdata_o, .mem_req_o, .mem_we_o, .mem_addr_o, .mem_be_o,
    .mem_wdata_o, .mem_ack_i, .mem_rdata_i
  );

  typedef struct {
    logic [19:0] a;
    logic [1:0]  be;
    logic        we;
    logic [15:0] wd;
    string       tag;
  } cyc_t;

  int          n_chk = 0, n_err = 0, wait_n = 0, wcnt = 0, cyc_cnt = 0;
  logic [7:0]  mem_m [int];
  logic [15:0] m_seg [4];
  bit          m_ovr_v = 0;
  logic [1:0]  m_ovr_id = '0;
  cyc_t        exp_q [$];
  cyc_t        e;

  function automatic logic [7:0] mrd(logic [19:0] a);
    if (mem_m.exists(int'(a))) return mem_m[int'(a)];
    return a[7:0] ^ a[15:8] ^ {4'h0, a[19:16]} ^ 8'h5A;
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // byte-lane memory with programmable wait states; also checks each cycle
  initial begin
    logic [19:0] base;
    forever begin
      @(negedge clk);
      if (mem_ack_i) mem_ack_i = 1'b0;
      else if (mem_req_o) begin
        if (exp_q.size() == 0) chk(0, "R11 unexpected bus cycle", 32'(mem_addr_o), 0);
        else begin
          e = exp_q[0];
          chk(mem_addr_o == e.a, {e.tag, " addr"}, 32'(mem_addr_o), 32'(e.a));
          chk(mem_be_o == e.be, {e.tag, " be"}, 32'(mem_be_o), 32'(e.be));
          chk(mem_we_o == e.we, {e.tag, " we"}, 32'(mem_we_o), 32'(e.we));
          if (e.we) chk(mem_wdata_o == e.wd, {e.tag, " wdata R9"}, 32'(mem_wdata_o), 32'(e.wd));
          if (wcnt >= wait_n) begin
            base = {mem_addr_o[19:1], 1'b0};
            mem_rdata_i = {mrd(base | 20'h1), mrd(base)};
            if (mem_we_o && mem_be_o[0]) mem_m[int'(base)] = mem_wdata_o[7:0];
            if (mem_we_o && mem_be_o[1]) mem_m[int'(base | 20'h1)] = mem_wdata_o[15:8];
            mem_ack_i = 1'b1;
            void'(exp_q.pop_front());
            wcnt = 0;
          end else wcnt++;
        end
      end
    end
  end

  task automatic seg_load(input logic [1:0] sel, input logic [15:0] v);
    @(negedge clk);
    seg_wr_i = 1'b1; seg_wr_sel_i = sel; seg_wr_data_i = v;
    @(negedge clk);
    seg_wr_i = 1'b0;
    m_seg[sel] = v;
  endtask

  task automatic ovr(input logic [1:0] id);
    @(negedge clk);
    ovr_set_i = 1'b1; ovr_seg_i = id;
    @(negedge clk);
    ovr_set_i = 1'b0;
    m_ovr_v = 1; m_ovr_id = id;
  endtask

  task automatic acc(input logic [1:0] cls, input logic [15:0] off, input bit wd,
                     input bit wr, input logic [15:0] wv, input string tag);
    logic [1:0]  sid;
    logic [19:0] p, p2;
    logic [15:0] er;
    int t;
    case (cls)
      2'd0: sid = 2'd1;
      2'd1: sid = 2'd3;
      2'd2: sid = 2'd2;
      default: sid = 2'd0;
    endcase
    if ((cls == 2'd1 || cls == 2'd2) && m_ovr_v) begin
      sid = m_ovr_id;
      m_ovr_v = 0;
    end
    p  = {m_seg[sid], 4'h0} + {4'h0, off};
    p2 = p + 20'h1;
    er = wd ? {mrd(p2), mrd(p)} : {8'h00, mrd(p)};
    if (!wd)       exp_q.push_back('{p, p[0] ? 2'b10 : 2'b01, wr, {2{wv[7:0]}}, tag});
    else if (!p[0]) exp_q.push_back('{p, 2'b11, wr, wv, tag});
    else begin
      exp_q.push_back('{p, 2'b10, wr, {2{wv[7:0]}}, tag});
      exp_q.push_back('{p2, 2'b01, wr, {2{wv[15:8]}}, tag});
    end
    @(negedge clk);
    req_i = 1'b1; cls_i = cls; offset_i = off; word_i = wd; we_i = wr; wdata_i = wv;
    t = 0;
    do begin
      @(negedge clk);
      t++;
    end while (!ready_o && t < 200);
    chk(ready_o, {tag, " R11 ready seen"}, 32'(ready_o), 1);
    if (!wr) chk(rdata_o == er, {tag, " rdata"}, 32'(rdata_o), 32'(er));
    req_i = 1'b0;
    chk(exp_q.size() == 0, {tag, " R11 all bus cycles done"}, exp_q.size(), 0);
    exp_q.delete();
    @(negedge clk);
    chk(!ready_o, {tag, " R11 ready single pulse"}, 32'(ready_o), 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc_cnt++;
      if (cyc_cnt > 100000) begin
        n_err++;
        n_chk++;
        $display("FAIL watchdog act=%0d exp=done", cyc_cnt);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
      end
    end
  end

  initial begin
    m_seg[0] = 16'h0000; m_seg[1] = 16'hFFFF; m_seg[2] = 16'h0000; m_seg[3] = 16'h0000;
    repeat (3) @(negedge clk);
    chk(!ready_o, "R1 ready low in reset", 32'(ready_o), 0);
    chk(!mem_req_o, "R1 mem_req low in reset", 32'(mem_req_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(!ready_o && !mem_req_o, "R1 idle after reset", 32'({ready_o, mem_req_o}), 0);

    acc(2'd0, 16'h0000, 1, 0, 0, "R1 fetch at FFFF0");
    acc(2'd1, 16'h1234, 1, 0, 0, "R6 even word data seg zero");
    acc(2'd2, 16'h0040, 1, 0, 0, "R1 stack seg zero");

    seg_load(2'd3, 16'h1000);
    seg_load(2'd2, 16'h2000);
    seg_load(2'd0, 16'h3000);
    acc(2'd1, 16'h0010, 0, 0, 0, "R5 R3 R8 data byte even");
    acc(2'd2, 16'h0021, 0, 0, 0, "R3 R8 stack byte odd");
    acc(2'd3, 16'h0004, 1, 0, 0, "R3 R2 extra word");
    acc(2'd0, 16'h0006, 1, 0, 0, "R3 fetch word");

    wait_n = 2;
    acc(2'd1, 16'h0101, 1, 0, 0, "R7 odd word read wait2");
    acc(2'd1, 16'h0201, 1, 1, 16'hBEEF, "R7 R9 odd word write");
    acc(2'd1, 16'h0200, 1, 0, 0, "R9 readback even word");
    acc(2'd1, 16'h0202, 0, 0, 0, "R9 readback high byte");
    acc(2'd2, 16'h0300, 1, 1, 16'hA55A, "R9 even word write");
    acc(2'd2, 16'h0300, 1, 0, 0, "R6 readback even word");
    acc(2'd3, 16'h0007, 0, 1, 16'h00C3, "R9 byte write odd");
    acc(2'd3, 16'h0006, 1, 0, 0, "R8 readback word holds byte");
    wait_n = 0;

    ovr(2'd0);
    acc(2'd0, 16'h0000, 0, 0, 0, "R4 fetch ignores override");
    acc(2'd1, 16'h0000, 0, 0, 0, "R4 data uses extra override");
    acc(2'd1, 16'h0000, 0, 0, 0, "R4 override consumed");
    ovr(2'd1);
    acc(2'd3, 16'h0002, 0, 0, 0, "R4 string dest ignores override");
    acc(2'd2, 16'h0002, 1, 0, 0, "R4 stack uses code override");
    acc(2'd2, 16'h0002, 1, 0, 0, "R4 stack back to default");

    seg_load(2'd2, 16'hF000);
    acc(2'd2, 16'hFFFF, 1, 0, 0, "R10 split wraps to zero");
    acc(2'd2, 16'hFFFF, 1, 1, 16'h1357, "R10 split write wraps");
    seg_load(2'd3, 16'hFFFF);
    acc(2'd1, 16'h0020, 0, 0, 0, "R2 sum wraps");
    acc(2'd1, 16'h000F, 1, 0, 0, "R2 top of space odd word");

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule